// File: doc/BRIEF.md
# Shared Interrupt Line Hold Arbiter

This block drives a bank of interrupt lines that many requesters share. Requesters are add-in card slots, each steered to one line by a routing table, and two motherboard sources, each with its own line selection and its own enable. Every line keeps one holder bit per requester. A level-mode line stays asserted as long as at least one holder bit is set. It drops only when the last holder lets go.

Edge-mode requests do not touch the holder bits. They produce a single-cycle pulse on a separate per-line edge output. Card requests take their mode from the routing style: with steerable routing they are level requests, and without it they are edge requests. A motherboard request carries its own mode bit. Two request channels, one for set and one for clear, are sampled each clock. Both are applied in the same cycle.

Top module: `irq_share_arbiter`

## Requirements
- R1: A synchronous active-low reset clears every holder bit. `line_level` and `line_edge` read all-zero on the clock after the reset edge.
- R2: A card request is a level request when `steer_en`=1 and an edge request when `steer_en`=0. A card clear made while `steer_en`=0 has no effect.
- R3: A motherboard request uses its own mode bit (`*_mode`: 1 = level, 0 = edge).
- R4: A level set from a source that is not holding a line asserts that line in `line_level` on the clock after the request. A repeated set from a source that already holds the line changes nothing, so one clear from that source releases it.
- R5: A line stays asserted while any holder remains. It deasserts on the clock after the clear from its last holder.
- R6: A level clear from a source that does not hold the line leaves the line and its holders unchanged.
- R7: An edge set gives a one-clock pulse on that line's bit of `line_edge`, on the clock after the request, whether the line is held or not. An edge set leaves `line_level` unchanged.
- R8: These requests are ignored: a motherboard request whose index is above 1, a motherboard request whose `mb_en` bit is 0, and a card request whose index is at or above NUM_CARDS.
- R9: A set and a clear in the same cycle from different sources are both applied. If both come from the same source on the same line, the clear wins and the source ends not holding.
- R10: Card c is routed to the line in `card_route[c*LINE_W +: LINE_W]`. Motherboard source m is routed to the line in `mb_route[m*LINE_W +: LINE_W]`. The `*_is_mb` bit selects the motherboard sources (1) or the card sources (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| steer_en | input | 1 | Steerable routing present: card requests are level mode |
| mb_en | input | 2 | Enable per motherboard source |
| card_route | input | NUM_CARDS*LINE_W | Line number for each card slot |
| mb_route | input | 2*LINE_W | Line number for each motherboard source |
| set_vld | input | 1 | Set request valid |
| set_is_mb | input | 1 | Set request comes from a motherboard source |
| set_src | input | 5 | Set request source index |
| set_mode | input | 1 | Set request mode for motherboard sources (1 = level) |
| clr_vld | input | 1 | Clear request valid |
| clr_is_mb | input | 1 | Clear request comes from a motherboard source |
| clr_src | input | 5 | Clear request source index |
| clr_mode | input | 1 | Clear request mode for motherboard sources (1 = level) |
| line_level | output | NUM_LINES | Asserted level of each line |
| line_edge | output | NUM_LINES | One-clock edge pulse per line |

## Verification
A set from one source and a clear from another can land on the same line in the same cycle. Each is applied to its own holder bit. The bench provokes this by clearing card 0 while card 1 sets the same line. It judges the result by the line staying high, and then by one clear from card 1 alone bringing the line low. That shows card 0 was really released. A same-source collision is also driven, and the line is expected to end low.

// File: rtl/irq_share_pkg.sv
// Package: shared constants for the interrupt line hold arbiter.
// Assumes request source indices are SRC_W bits wide and that there are
// exactly MB_COUNT motherboard sources.
package irq_share_pkg;
    localparam int SRC_W    = 5;
    localparam int MB_COUNT = 2;
    localparam logic MODE_LEVEL = 1'b1;
endpackage

// File: rtl/irq_req_decode.sv
// Module: irq_req_decode
// Turns one request (source kind, index, mode) into a target line, a holder
// bit, an accept flag and an effective trigger mode.
// Assumes: card holder bits sit at [NUM_CARDS-1:0] and motherboard bits sit
// directly above them.
module irq_req_decode
    import irq_share_pkg::*;
#(
    parameter int NUM_CARDS = 4,
    parameter int NUM_LINES = 16,
    parameter int LINE_W    = 4,
    parameter int HELD_W    = 6
) (
    input  logic                        req_vld,
    input  logic                        req_is_mb,
    input  logic [SRC_W-1:0]            req_src,
    input  logic                        req_mode,
    input  logic                        steer_en,
    input  logic [MB_COUNT-1:0]         mb_en,
    input  logic [NUM_CARDS*LINE_W-1:0] card_route,
    input  logic [MB_COUNT*LINE_W-1:0]  mb_route,
    output logic                        go,
    output logic                        is_level,
    output logic [LINE_W-1:0]           line_sel,
    output logic [HELD_W-1:0]           hold_bit
);
    localparam int LW1 = LINE_W + 1;

    logic accept;
    logic line_ok;

    // Purpose: select route, holder bit and mode for the requesting source.
    always_comb begin
        accept   = 1'b0;
        is_level = 1'b0;
        line_sel = '0;
        hold_bit = '0;
        if (req_is_mb) begin
            if (req_src < SRC_W'(MB_COUNT)) begin
                for (int m = 0; m < MB_COUNT; m++) begin
                    if (req_src == SRC_W'(m)) begin
                        accept   = mb_en[m];
                        line_sel = mb_route[m*LINE_W +: LINE_W];
                        hold_bit[NUM_CARDS + m] = 1'b1;
                    end
                end
                is_level = (req_mode == MODE_LEVEL);
            end
        end else begin
            if (req_src < SRC_W'(NUM_CARDS)) begin
                for (int c = 0; c < NUM_CARDS; c++) begin
                    if (req_src == SRC_W'(c)) begin
                        line_sel = card_route[c*LINE_W +: LINE_W];
                        hold_bit[c] = 1'b1;
                    end
                end
                accept   = 1'b1;
                is_level = steer_en;
            end
        end
    end

    // Purpose: refuse a route that points past the last line.
    assign line_ok = ({1'b0, line_sel} < LW1'(NUM_LINES));
    assign go      = req_vld & accept & line_ok;
endmodule

// File: rtl/irq_hold_bank.sv
// Module: irq_hold_bank
// Keeps one holder bitmap per line and drives each line's level as the OR
// of its holders. Assumes each request channel carries a one-hot holder bit.
module irq_hold_bank #(
    parameter int NUM_LINES = 16,
    parameter int LINE_W    = 4,
    parameter int HELD_W    = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 set_lvl,
    input  logic [LINE_W-1:0]    set_line,
    input  logic [HELD_W-1:0]    set_bit,
    input  logic                 clr_lvl,
    input  logic [LINE_W-1:0]    clr_line,
    input  logic [HELD_W-1:0]    clr_bit,
    output logic [NUM_LINES-1:0] line_level
);
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic [HELD_W-1:0] holders;
        logic [HELD_W-1:0] holders_nxt;

        // Purpose: add the setter's bit, then remove the clearer's bit.
        always_comb begin
            holders_nxt = holders;
            if (set_lvl && (set_line == LINE_W'(l)))
                holders_nxt = holders_nxt | set_bit;
            if (clr_lvl && (clr_line == LINE_W'(l)))
                holders_nxt = holders_nxt & ~clr_bit;
        end

        // Purpose: holder register with synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) holders <= '0;
            else        holders <= holders_nxt;
        end

        assign line_level[l] = |holders;
    end
endmodule

// File: rtl/irq_edge_pulse.sv
// Module: irq_edge_pulse
// Registers a one-clock pulse on the line chosen by an edge set request.
// Assumes at most one edge request per cycle.
module irq_edge_pulse #(
    parameter int NUM_LINES = 16,
    parameter int LINE_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fire,
    input  logic [LINE_W-1:0]    line_sel,
    output logic [NUM_LINES-1:0] pulse
);
    // Purpose: set one pulse bit for a single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= '0;
        end else begin
            pulse <= '0;
            for (int l = 0; l < NUM_LINES; l++)
                if (fire && (line_sel == LINE_W'(l))) pulse[l] <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_share_arbiter.sv
// Module: irq_share_arbiter (top)
// Arbitrates shared interrupt lines among card slots and motherboard sources.
// Level requests are tracked in per-line holder bitmaps, and edge requests
// become one-clock pulses. Assumes NUM_CARDS + 2 <= 32 and routing inputs
// held steady by the surrounding configuration logic.
module irq_share_arbiter
    import irq_share_pkg::*;
#(
    parameter int NUM_CARDS = 4,
    parameter int NUM_LINES = 16,
    parameter int LINE_W    = $clog2(NUM_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        steer_en,
    input  logic [1:0]                  mb_en,
    input  logic [NUM_CARDS*LINE_W-1:0] card_route,
    input  logic [2*LINE_W-1:0]         mb_route,
    input  logic                        set_vld,
    input  logic                        set_is_mb,
    input  logic [4:0]                  set_src,
    input  logic                        set_mode,
    input  logic                        clr_vld,
    input  logic                        clr_is_mb,
    input  logic [4:0]                  clr_src,
    input  logic                        clr_mode,
    output logic [NUM_LINES-1:0]        line_level,
    output logic [NUM_LINES-1:0]        line_edge
);
    localparam int HELD_W = NUM_CARDS + MB_COUNT;

    logic              set_go, set_is_lvl, clr_go, clr_is_lvl;
    logic [LINE_W-1:0] set_line, clr_line;
    logic [HELD_W-1:0] set_bit, clr_bit;
    logic              set_lvl, set_edg, clr_lvl;

    irq_req_decode #(
        .NUM_CARDS(NUM_CARDS), .NUM_LINES(NUM_LINES),
        .LINE_W(LINE_W), .HELD_W(HELD_W)
    ) u_set_dec (
        .req_vld(set_vld), .req_is_mb(set_is_mb), .req_src(set_src),
        .req_mode(set_mode), .steer_en(steer_en), .mb_en(mb_en),
        .card_route(card_route), .mb_route(mb_route),
        .go(set_go), .is_level(set_is_lvl), .line_sel(set_line),
        .hold_bit(set_bit)
    );

    irq_req_decode #(
        .NUM_CARDS(NUM_CARDS), .NUM_LINES(NUM_LINES),
        .LINE_W(LINE_W), .HELD_W(HELD_W)
    ) u_clr_dec (
        .req_vld(clr_vld), .req_is_mb(clr_is_mb), .req_src(clr_src),
        .req_mode(clr_mode), .steer_en(steer_en), .mb_en(mb_en),
        .card_route(card_route), .mb_route(mb_route),
        .go(clr_go), .is_level(clr_is_lvl), .line_sel(clr_line),
        .hold_bit(clr_bit)
    );

    // Purpose: split accepted requests by effective trigger mode.
    assign set_lvl = set_go & set_is_lvl;
    assign set_edg = set_go & ~set_is_lvl;
    assign clr_lvl = clr_go & clr_is_lvl;

    irq_hold_bank #(
        .NUM_LINES(NUM_LINES), .LINE_W(LINE_W), .HELD_W(HELD_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .set_lvl(set_lvl), .set_line(set_line), .set_bit(set_bit),
        .clr_lvl(clr_lvl), .clr_line(clr_line), .clr_bit(clr_bit),
        .line_level(line_level)
    );

    irq_edge_pulse #(
        .NUM_LINES(NUM_LINES), .LINE_W(LINE_W)
    ) u_edge (
        .clk(clk), .rst_n(rst_n), .fire(set_edg),
        .line_sel(set_line), .pulse(line_edge)
    );
endmodule

// File: rtl/irq_share_arbiter_chk.sv
// Module: irq_share_arbiter_chk
// Port-level temporal checks on the arbiter, attached with bind.
module irq_share_arbiter_chk #(
    parameter int NUM_LINES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 set_vld,
    input logic                 clr_vld,
    input logic [NUM_LINES-1:0] line_level,
    input logic [NUM_LINES-1:0] line_edge
);
    // A line can only rise after a set request.
    p_rise_needs_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ((line_level & ~$past(line_level)) != '0)) |-> $past(set_vld));

    // A line can only fall after a clear request.
    p_fall_needs_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ((~line_level & $past(line_level)) != '0)) |-> $past(clr_vld));

    // With no request at all, the levels hold still.
    p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(set_vld) && !$past(clr_vld)) |-> $stable(line_level));

    // One set channel gives at most one edge pulse per cycle.
    p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(line_edge));

    // A pulse follows a set request.
    p_pulse_needs_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (line_edge != '0)) |-> $past(set_vld));
endmodule

bind irq_share_arbiter irq_share_arbiter_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .set_vld(set_vld), .clr_vld(clr_vld),
    .line_level(line_level), .line_edge(line_edge)
);

// File: tb/tb_irq_share_arbiter.sv
// Directed bench for irq_share_arbiter: one task per scenario.
module tb_irq_share_arbiter;
    localparam int NC = 4;
    localparam int NL = 16;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          steer_en = 1'b1;
    logic [1:0]    mb_en = 2'b11;
    logic [NC*LW-1:0] card_route = {4'd5, 4'd7, 4'd3, 4'd3};
    logic [2*LW-1:0]  mb_route = {4'd9, 4'd3};
    logic          set_vld = 0, set_is_mb = 0, set_mode = 0;
    logic [4:0]    set_src = '0;
    logic          clr_vld = 0, clr_is_mb = 0, clr_mode = 0;
    logic [4:0]    clr_src = '0;
    logic [NL-1:0] line_level, line_edge;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_share_arbiter #(.NUM_CARDS(NC), .NUM_LINES(NL)) dut (
        .clk(clk), .rst_n(rst_n), .steer_en(steer_en), .mb_en(mb_en),
        .card_route(card_route), .mb_route(mb_route),
        .set_vld(set_vld), .set_is_mb(set_is_mb), .set_src(set_src),
        .set_mode(set_mode), .clr_vld(clr_vld), .clr_is_mb(clr_is_mb),
        .clr_src(clr_src), .clr_mode(clr_mode),
        .line_level(line_level), .line_edge(line_edge)
    );

    task automatic chk(input string tag, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive both channels for one clock, then sample at the following negedge.
    task automatic issue(input logic sv, input logic smb, input int ss, input logic sm,
                         input logic cv, input logic cmb, input int cs, input logic cm);
        @(negedge clk);
        set_vld = sv; set_is_mb = smb; set_src = 5'(ss); set_mode = sm;
        clr_vld = cv; clr_is_mb = cmb; clr_src = 5'(cs); clr_mode = cm;
        @(negedge clk);
        set_vld = 0; clr_vld = 0;
    endtask

    task automatic set_req(input logic mb, input int s, input logic m);
        issue(1, mb, s, m, 0, 0, 0, 0);
    endtask

    task automatic clr_req(input logic mb, input int s, input logic m);
        issue(0, 0, 0, 0, 1, mb, s, m);
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        chk("R1 level after reset", line_level, '0);
        chk("R1 edge after reset", line_edge, '0);
    endtask

    task automatic t_card_level();
        steer_en = 1;
        set_req(0, 0, 0);
        chk("R2 R10 card0 level on line3", line_level, 16'h0008);
        chk("R2 no pulse for level card", line_edge, '0);
        set_req(0, 0, 0);
        chk("R4 repeated set", line_level, 16'h0008);
        clr_req(0, 0, 0);
        chk("R4 single clear releases", line_level, '0);
    endtask

    task automatic t_share();
        set_req(0, 0, 0);
        set_req(0, 1, 0);
        chk("R5 two holders", line_level, 16'h0008);
        clr_req(0, 0, 0);
        chk("R5 one holder left", line_level, 16'h0008);
        clr_req(0, 1, 0);
        chk("R5 last holder released", line_level, '0);
    endtask

    task automatic t_nonholder();
        set_req(0, 0, 0);
        clr_req(0, 1, 0);
        chk("R6 clear from non-holder", line_level, 16'h0008);
        clr_req(0, 0, 0);
        chk("R6 true holder releases", line_level, '0);
    endtask

    task automatic t_edge_card();
        steer_en = 0;
        set_req(0, 2, 1);
        chk("R2 R7 unsteered card pulse line7", line_edge, 16'h0080);
        chk("R7 edge leaves level", line_level, '0);
        idle();
        chk("R7 pulse lasts one clock", line_edge, '0);
        steer_en = 1;
        set_req(0, 0, 0);
        steer_en = 0;
        clr_req(0, 0, 0);
        chk("R2 unsteered card clear ignored", line_level, 16'h0008);
        steer_en = 1;
        clr_req(0, 0, 0);
        chk("R2 steered clear releases", line_level, '0);
    endtask

    task automatic t_edge_over_held();
        set_req(0, 0, 0);
        set_req(1, 0, 0);
        chk("R3 R7 mb0 edge on held line3", line_edge, 16'h0008);
        chk("R7 held line stays", line_level, 16'h0008);
        clr_req(0, 0, 0);
        chk("R7 edge added no holder", line_level, '0);
    endtask

    task automatic t_mb_level();
        set_req(1, 1, 1);
        chk("R3 R10 mb1 level line9", line_level, 16'h0200);
        clr_req(1, 1, 0);
        chk("R3 mb1 edge-mode clear no effect", line_level, 16'h0200);
        clr_req(1, 1, 1);
        chk("R3 mb1 level clear", line_level, '0);
    endtask

    task automatic t_ignore();
        mb_en = 2'b01;
        set_req(1, 1, 1);
        chk("R8 disabled mb1 level", line_level, '0);
        set_req(1, 1, 0);
        chk("R8 disabled mb1 edge", line_edge, '0);
        mb_en = 2'b11;
        set_req(1, 2, 0);
        chk("R8 mb index 2 edge", line_edge, '0);
        set_req(1, 3, 1);
        chk("R8 mb index 3 level", line_level, '0);
        set_req(0, 5, 0);
        chk("R8 card index 5 level", line_level, '0);
        chk("R8 card index 5 edge", line_edge, '0);
    endtask

    task automatic t_same_cycle();
        set_req(0, 0, 0);
        issue(1, 0, 1, 0, 1, 0, 0, 0);
        chk("R9 set and clear both applied", line_level, 16'h0008);
        clr_req(0, 1, 0);
        chk("R9 card0 was cleared", line_level, '0);
        issue(1, 0, 2, 0, 1, 0, 2, 0);
        chk("R9 same source clear wins", line_level, '0);
    endtask

    task automatic t_reset_mid();
        set_req(0, 0, 0);
        set_req(1, 1, 1);
        chk("R1 holds before reset", line_level, 16'h0208);
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
        chk("R1 reset clears holders", line_level, '0);
        chk("R1 reset clears pulses", line_edge, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();
        t_reset_state();
        t_card_level();
        t_share();
        t_nonholder();
        t_edge_card();
        t_edge_over_held();
        t_mb_level();
        t_ignore();
        t_same_cycle();
        t_reset_mid();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule